// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This unit keeps the eight-bit status word of a serial memory and decides, cycle by cycle, whether a status write or an array write may go ahead. It combines three protection sources. The first is a block-protect level that covers zero, one, two or all four quarters of the array, counted from the top address down. The second is a write-enable latch that software must set before each write and that clears again when the write ends. The third is a hardware protect pin, which gates status writes only when a lock bit in the status word is set.

The serial command decoder drives this unit with single-cycle pulses: set enable, clear enable, end of write, and a status commit with its byte. It also gives the address to check, the protect pin level and the busy flag from the write engine. The decoder returns the status byte to the bus, and it uses the two permission flags to accept or discard a write. The protect level and the lock bit model nonvolatile cells. A soft power-cycle pulse leaves them untouched but drops the enable latch. The hard reset clears everything.

Top module: `sr_protect_unit`

## Requirements
- R1: When not busy, the status byte is {lock, 0, 0, 0, level[1], level[0], enable, 0}: bit 7 is the lock bit, bits 3:2 are the protect level, bit 1 is the enable latch, and bits 6:4 and bit 0 read 0.
- R2: While busy is 1, the status byte reads 8'hFF.
- R3: The protect level marks the protected addresses, with A the address width and the top two address bits giving the quarter. Level 00 protects nothing. Level 01 protects quarter 3 (0x180-0x1FF at A=9). Level 10 protects quarters 2 and 3 (0x100-0x1FF). Level 11 protects every address.
- R4: Hard reset clears the enable latch, the level and the lock bit. A power-cycle pulse clears the enable latch at the next edge, keeps the level and the lock bit, and discards a status commit in the same cycle.
- R5: An end-of-write pulse clears the enable latch at the next edge whatever the busy state, and it overrides a set-enable pulse.
- R6: sr_write_ok is 1 exactly when the enable latch is 1, busy is 0, and not (lock bit = 1 and wp_n = 0).
- R7: arr_write_ok is 1 exactly when the enable latch is 1, busy is 0 and the checked address is not protected. The wp_n pin has no effect on it.
- R8: When not busy, a clear-enable pulse clears the latch whatever wp_n is, and a set-enable pulse sets it. If both arrive in the same cycle, clearing wins.
- R9: While busy, the set-enable and clear-enable pulses have no effect on the latch.
- R10: A status commit made while sr_write_ok is 1 loads only data bits 7 (lock) and 3:2 (level) at the next edge. The enable latch and the other status bits stay as they are. A commit made while sr_write_ok is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| pwr_cycle | input | 1 | Soft power-cycle pulse |
| wren | input | 1 | Set-enable pulse |
| wrdi | input | 1 | Clear-enable pulse |
| wr_end | input | 1 | End-of-write-instruction pulse |
| busy | input | 1 | Internal write cycle in progress |
| wp_n | input | 1 | Hardware protect pin, active low |
| wrsr_commit | input | 1 | Status write commit strobe |
| wrsr_data | input | 8 | Byte offered for the status write |
| chk_addr | input | ADDR_W | Array address being checked |
| rdsr_byte | output | 8 | Status byte returned to the bus |
| sr_write_ok | output | 1 | Status write allowed |
| arr_write_ok | output | 1 | Array write to chk_addr allowed |
| wen | output | 1 | Current enable latch |

## Verification
The bench targets the quarter boundaries at 0x17F/0x180 and 0xFF/0x100. A decoder that is off by one quarter there would accept or refuse a write at the wrong addresses. It drives the protect pin low with the lock bit both clear and set. A pin gate wired without the lock bit would block status writes all the time, and a gate wired into the array path would block array writes it must allow. It commits all-ones bytes to catch a commit that leaks into the enable or unused bits. It also sends power-cycle pulses to catch a design that loses the nonvolatile bits. Finally, it fires enable pulses while busy, and set and clear together, because a wrong priority order would leave the latch in the wrong state.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_W       = 8;
  localparam int NV_W       = 3;
  localparam int BIT_LOCK   = 7;
  localparam int BIT_LVL_HI = 3;
  localparam int BIT_LVL_LO = 2;
  localparam int BIT_EN     = 1;
  localparam int BIT_RDY    = 0;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_level_t;

  typedef struct packed {
    logic        lock;
    prot_level_t level;
  } nv_bits_t;
endpackage

// File: rtl/sr_wen_latch.sv
module sr_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_cycle,
  input  logic wr_end,
  input  logic busy,
  input  logic wren,
  input  logic wrdi,
  output logic wen
);
  logic wen_q;
  logic wen_d;

  // priority: power cycle, end of write, then enable pulses when idle
  always_comb begin
    wen_d = wen_q;
    if (pwr_cycle)      wen_d = 1'b0;
    else if (wr_end)    wen_d = 1'b0;
    else if (!busy) begin
      if (wrdi)         wen_d = 1'b0;
      else if (wren)    wen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wen_q <= 1'b0;
    else        wen_q <= wen_d;
  end

  assign wen = wen_q;
endmodule

// File: rtl/sr_nv_bits.sv
module sr_nv_bits #(
  parameter int NV_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [NV_W-1:0] load_val,
  output logic [NV_W-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < NV_W; gi++) begin : g_cell
      logic cell_q;
      logic cell_d;

      always_comb begin
        cell_d = cell_q;
        if (load_en) cell_d = load_val[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= 1'b0;
        else        cell_q <= cell_d;
      end

      assign q[gi] = cell_q;
    end
  endgenerate
endmodule

// File: rtl/sr_prot_decode.sv
module sr_prot_decode
  import sr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  prot_level_t       level,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int SEG_W = 2;
  logic [SEG_W-1:0] seg;

  assign seg = addr[ADDR_W-1 -: SEG_W];

  always_comb begin
    unique case (level)
      LVL_NONE:    prot = 1'b0;
      LVL_QUARTER: prot = (seg == 2'b11);
      LVL_HALF:    prot = seg[1];
      default:     prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
  import sr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_cycle,
  input  logic              wren,
  input  logic              wrdi,
  input  logic              wr_end,
  input  logic              busy,
  input  logic              wp_n,
  input  logic              wrsr_commit,
  input  logic [SR_W-1:0]   wrsr_data,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [SR_W-1:0]   rdsr_byte,
  output logic              sr_write_ok,
  output logic              arr_write_ok,
  output logic              wen
);
  logic [NV_W-1:0] nv_q;
  logic [NV_W-1:0] nv_load;
  nv_bits_t        nv;
  logic            commit_en;
  logic            pin_lock;
  logic            addr_prot;

  sr_wen_latch u_wen (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_cycle (pwr_cycle),
    .wr_end    (wr_end),
    .busy      (busy),
    .wren      (wren),
    .wrdi      (wrdi),
    .wen       (wen)
  );

  assign nv_load = {wrsr_data[BIT_LOCK], wrsr_data[BIT_LVL_HI], wrsr_data[BIT_LVL_LO]};

  sr_nv_bits #(.NV_W(NV_W)) u_nv (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (commit_en),
    .load_val (nv_load),
    .q        (nv_q)
  );

  assign nv = nv_bits_t'(nv_q);

  sr_prot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .level (nv.level),
    .addr  (chk_addr),
    .prot  (addr_prot)
  );

  assign pin_lock     = nv.lock & ~wp_n;
  assign sr_write_ok  = wen & ~busy & ~pin_lock;
  assign arr_write_ok = wen & ~busy & ~addr_prot;
  assign commit_en    = wrsr_commit & sr_write_ok & ~pwr_cycle;

  always_comb begin
    rdsr_byte = '0;
    if (busy) begin
      rdsr_byte = '1;
    end else begin
      rdsr_byte[BIT_LOCK]   = nv.lock;
      rdsr_byte[BIT_LVL_HI] = nv.level[1];
      rdsr_byte[BIT_LVL_LO] = nv.level[0];
      rdsr_byte[BIT_EN]     = wen;
      rdsr_byte[BIT_RDY]    = 1'b0;
    end
  end
endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_cycle,
  input logic       wren,
  input logic       wrdi,
  input logic       wr_end,
  input logic       busy,
  input logic       wp_n,
  input logic       wrsr_commit,
  input logic [7:0] rdsr_byte,
  input logic       sr_write_ok,
  input logic       arr_write_ok,
  input logic       wen,
  input logic [2:0] nv_q
);
  a_r1_idle_layout: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rdsr_byte[6:4] == 3'b000 && !rdsr_byte[0] && rdsr_byte[1] == wen));

  a_r2_busy_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rdsr_byte == 8'hFF);

  a_r3_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_q[1:0] == 2'b11) |-> !arr_write_ok);

  a_r4_pwr_keeps_nv: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> (!wen && $stable(nv_q)));

  a_r5_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> !wen);

  a_r6_sr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sr_write_ok |-> (wen && !busy && !(nv_q[2] && !wp_n)));

  a_r7_arr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    arr_write_ok |-> (wen && !busy));

  a_r8_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wrdi && !busy) |=> !wen);

  a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_end && !pwr_cycle) |=> $stable(wen));

  a_r10_blocked_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_commit && !sr_write_ok) |=> $stable(nv_q));

  a_r8_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wren && !wrdi && !busy && !wr_end && !pwr_cycle) |=> wen);
endmodule

bind sr_protect_unit sr_protect_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_cycle    (pwr_cycle),
  .wren         (wren),
  .wrdi         (wrdi),
  .wr_end       (wr_end),
  .busy         (busy),
  .wp_n         (wp_n),
  .wrsr_commit  (wrsr_commit),
  .rdsr_byte    (rdsr_byte),
  .sr_write_ok  (sr_write_ok),
  .arr_write_ok (arr_write_ok),
  .wen          (wen),
  .nv_q         (nv_q)
);

// File: tb/tb_sr_protect_unit.sv
module tb_sr_protect_unit;
  localparam int AW = 9;

  logic          clk;
  logic          rst_n;
  logic          pwr_cycle, wren, wrdi, wr_end, busy, wp_n, wrsr_commit;
  logic [7:0]    wrsr_data;
  logic [AW-1:0] chk_addr;
  logic [7:0]    rdsr_byte;
  logic          sr_write_ok, arr_write_ok, wen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       m_wen, m_lock;
  logic [1:0] m_lvl;
  string      wen_tag;

  sr_protect_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .wren(wren), .wrdi(wrdi),
    .wr_end(wr_end), .busy(busy), .wp_n(wp_n), .wrsr_commit(wrsr_commit),
    .wrsr_data(wrsr_data), .chk_addr(chk_addr), .rdsr_byte(rdsr_byte),
    .sr_write_ok(sr_write_ok), .arr_write_ok(arr_write_ok), .wen(wen)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic f_prot(logic [1:0] lvl, logic [AW-1:0] a);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return a >= 9'd384;
      2'd2:    return a >= 9'd256;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] f_status(logic b, logic lk, logic [1:0] lv, logic en);
    if (b) return 8'hFF;
    return {lk, 3'b000, lv, en, 1'b0};
  endfunction

  function automatic logic f_sr_ok(logic en, logic b, logic lk, logic pin);
    return en && !b && !(lk && !pin);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic p, logic se, logic ce, logic we, logic b, logic pin,
                      logic cm, logic [7:0] d, logic [AW-1:0] a);
    logic ok;
    pwr_cycle = p; wren = se; wrdi = ce; wr_end = we; busy = b; wp_n = pin;
    wrsr_commit = cm; wrsr_data = d; chk_addr = a;
    #2;
    chk(b ? "R2" : "R1 R10", rdsr_byte, f_status(b, m_lock, m_lvl, m_wen));
    chk(wen_tag, {7'd0, wen}, {7'd0, m_wen});
    ok = f_sr_ok(m_wen, b, m_lock, pin);
    chk("R6", {7'd0, sr_write_ok}, {7'd0, ok});
    chk("R3 R7", {7'd0, arr_write_ok}, {7'd0, m_wen && !b && !f_prot(m_lvl, a)});
    @(posedge clk);
    if (cm && ok && !p) begin
      m_lock = d[7];
      m_lvl  = d[3:2];
    end
    if (p)        begin m_wen = 1'b0; wen_tag = "R4"; end
    else if (we)  begin m_wen = 1'b0; wen_tag = "R5"; end
    else if (b)   wen_tag = "R9";
    else if (ce)  begin m_wen = 1'b0; wen_tag = "R8"; end
    else if (se)  begin m_wen = 1'b1; wen_tag = "R8"; end
    @(negedge clk);
  endtask

  task automatic idle(logic [AW-1:0] a);
    step(0, 0, 0, 0, 0, 1, 0, 8'h00, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; pwr_cycle = 0; wren = 0; wrdi = 0; wr_end = 0; busy = 0;
    wp_n = 1; wrsr_commit = 0; wrsr_data = 0; chk_addr = 0;
    m_wen = 0; m_lock = 0; m_lvl = 0; wen_tag = "R4";
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R4", rdsr_byte, 8'h00);
    chk("R4", {7'd0, wen}, 8'h00);
    @(negedge clk);

    // set enable, commit all ones: only lock and level land
    step(0, 1, 0, 0, 0, 1, 0, 8'h00, 9'h000);
    step(0, 0, 0, 0, 0, 1, 1, 8'hFF, 9'h000);
    #2; chk("R10", rdsr_byte, 8'h8E);
    step(0, 0, 0, 1, 0, 1, 0, 8'h00, 9'h000);
    #2; chk("R5", rdsr_byte, 8'h8C);
    // power cycle keeps nonvolatile bits
    step(0, 1, 0, 0, 0, 1, 0, 8'h00, 9'h000);
    step(1, 0, 0, 0, 0, 1, 0, 8'h00, 9'h000);
    #2; chk("R4", rdsr_byte, 8'h8C);
    // lock set, pin low: status write refused, array check free of pin
    step(0, 1, 0, 0, 0, 1, 0, 8'h00, 9'h000);
    step(0, 0, 0, 0, 0, 0, 1, 8'h04, 9'h000);
    #2; chk("R6", rdsr_byte, 8'h8E);
    // pin high: change to quarter level
    step(0, 0, 0, 0, 0, 1, 1, 8'h04, 9'h000);
    #2; chk("R10", rdsr_byte, 8'h06);
    idle(9'h17F); idle(9'h180); idle(9'h1FF);
    step(0, 0, 0, 0, 0, 0, 1, 8'h08, 9'h17F);
    idle(9'h0FF); idle(9'h100);
    // enable pulses while busy; set and clear together
    step(0, 0, 1, 0, 1, 1, 0, 8'h00, 9'h000);
    step(0, 0, 0, 0, 0, 1, 0, 8'h00, 9'h000);
    #2; chk("R9", {7'd0, wen}, 8'h01);
    step(0, 1, 1, 0, 0, 0, 0, 8'h00, 9'h000);
    #2; chk("R8", {7'd0, wen}, 8'h00);
    step(0, 1, 0, 0, 1, 1, 0, 8'h00, 9'h000);
    #2; chk("R9", {7'd0, wen}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 99) < 2,  $urandom_range(0, 99) < 35,
           $urandom_range(0, 99) < 10, $urandom_range(0, 99) < 10,
           $urandom_range(0, 99) < 20, $urandom_range(0, 99) < 65,
           $urandom_range(0, 99) < 25, 8'($urandom()), AW'($urandom()));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule